// File: doc/BRIEF.md
# Interrupt Priority Resolver With Preemption

This block holds a programmable urgency level for each of 48 peripheral interrupt lines and decides which of them, if any, should be signalled to the processor. Software programs the levels through a 32-bit word register port. Each word packs four one-byte fields, and only the upper four bits of each byte are stored. The surrounding interrupt controller supplies a vector with one bit per line that is set when the line is both enabled and pending. It also supplies the priority of the context that is currently running.

Each cycle the block looks for the most urgent candidate. A smaller value is more urgent, and a tie goes to the smaller line number. The block registers the winner's number and level. It asserts its request flag only when that level is strictly more urgent than the running context. The running-priority input is a signed number. Negative values stand for fixed system exceptions, which outrank every peripheral line. Values of 256 and above mean that no handler is running.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset every priority field reads 0, and `req_valid`, `req_id` and `req_prio` are all 0.
- R2: Priority word k sits at byte address 0x400 + 4k, for k = 0..11. Interrupt 4k+j owns byte lane j of that word, which is bits 8j+7:8j. A read returns the stored fields, and `bus_rdata` follows `bus_addr` combinationally.
- R3: Only bits 7:4 of each field are kept, giving levels 0, 16, ..., 240. Bits 3:0 always read as 0, whatever was written.
- R4: A write (`bus_we` high at a rising edge) updates only the lanes whose `bus_wstrb` bit is set. Writes to addresses outside 0x400..0x42F change nothing, and reads there return 0.
- R5: Only lines whose `cand_vec` bit is 1 take part in selection. With no candidate, `req_valid`, `req_id` and `req_prio` are all 0.
- R6: The candidate with the numerically smallest priority value wins. Its number appears on `req_id` and its 8-bit priority value (low nibble 0) on `req_prio`, whether or not it preempts.
- R7: Among candidates that share the best priority value, the lowest interrupt number wins.
- R8: `req_valid` is 1 only when a winner exists and its priority value is strictly less than `run_prio`, compared as signed integers. An equal value does not raise a request.
- R9: A negative `run_prio` (a system exception is running) suppresses every request. A `run_prio` of 256 or more (no handler is running) lets any candidate through, including one at level 240.
- R10: The outputs are registered. They reflect `cand_vec`, `run_prio` and the stored priorities as they stand just before a rising edge. A priority write therefore shows in the outputs after the edge that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write enable for the priority registers |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cand_vec | input | 48 | One bit per line that is enabled and pending |
| run_prio | input | 10 | Signed priority of the running context (negative: system exception, 256 and above: idle) |
| req_valid | output | 1 | The winner preempts the running context |
| req_id | output | 6 | Number of the winning line |
| req_prio | output | 8 | Priority value of the winning line |

## Verification
The hardest situation to reach is a tie that has to be broken by line number while the winner's level exactly equals the running priority, so that a correct ID appears with the request flag held low. The stimulus reaches it by programming two widely separated lines to the same level through single-lane strobed writes. It then sweeps `run_prio` across that level and its neighbours. Another single-lane write lifts one of the tied lines, and the next vector confirms that the winner moves one cycle later. A pseudo-random phase follows, mixing sparse and dense candidate vectors with running priorities that cover negative, in-range and idle values.

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int N_IRQ     = 48,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W    = 12,
  parameter int RUN_W     = 10,
  parameter logic [ADDR_W-1:0] BASE = 12'h400,
  parameter int ID_W      = $clog2(N_IRQ)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [3:0]              bus_wstrb,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [N_IRQ-1:0]        cand_vec,
  input  logic signed [RUN_W-1:0] run_prio,
  output logic                    req_valid,
  output logic [ID_W-1:0]         req_id,
  output logic [7:0]              req_prio
);
  localparam int N_WORDS = (N_IRQ + 3) / 4;
  localparam int PAD     = 8 - PRIO_BITS;
  localparam int WIDX_W  = ADDR_W - 2;

  logic [PRIO_BITS-1:0] prio_q [N_IRQ];

  logic [ADDR_W-1:0] off;
  logic [WIDX_W-1:0] widx;
  logic              in_win;

  assign off    = bus_addr - BASE;
  assign widx   = off[ADDR_W-1:2];
  assign in_win = (bus_addr >= BASE) && (widx < WIDX_W'(N_WORDS));

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_IRQ; i++) begin
      if (!rst_n)
        prio_q[i] <= '0;
      else if (bus_we && in_win && widx == WIDX_W'(i / 4) && bus_wstrb[i % 4])
        prio_q[i] <= bus_wdata[8*(i%4)+7 -: PRIO_BITS];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (in_win && widx == WIDX_W'(i / 4))
        bus_rdata[8*(i%4) +: 8] = {prio_q[i], {PAD{1'b0}}};
  end

  logic                 found;
  logic [ID_W-1:0]      best_id;
  logic [PRIO_BITS-1:0] best_p;
  logic [7:0]           best8;
  logic                 preempt;

  always_comb begin
    found   = 1'b0;
    best_id = '0;
    best_p  = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cand_vec[i] && (!found || prio_q[i] < best_p)) begin
        found   = 1'b1;
        best_id = ID_W'(i);
        best_p  = prio_q[i];
      end
    end
  end

  assign best8   = {best_p, {PAD{1'b0}}};
  assign preempt = found && ($signed({{(RUN_W-8){1'b0}}, best8}) < run_prio);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_id    <= '0;
      req_prio  <= '0;
    end else begin
      req_valid <= preempt;
      req_id    <= best_id;
      req_prio  <= best8;
    end
  end

  p_sys_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_prio) < 0) |-> !req_valid);

  p_idle_grants_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(run_prio) > 10'sd255 && (|$past(cand_vec))) |-> req_valid);

  p_strict_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($signed({{(RUN_W-8){1'b0}}, req_prio}) < $past(run_prio)));

  p_winner_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (|($past(cand_vec) & (N_IRQ'(1) << req_id))));

  p_none_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cand_vec) == '0) |-> (req_id == '0 && req_prio == '0 && !req_valid));

  p_id_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_id < ID_W'(N_IRQ));
endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
  logic               clk = 0;
  logic               rst_n = 0;
  logic               bus_we = 0;
  logic [11:0]        bus_addr = '0;
  logic [3:0]         bus_wstrb = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic [47:0]        cand_vec = '0;
  logic signed [9:0]  run_prio = 10'sd256;
  logic               req_valid;
  logic [5:0]         req_id;
  logic [7:0]         req_prio;

  always #5 clk = ~clk;

  irq_prio_arbiter u_irq_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cand_vec(cand_vec), .run_prio(run_prio), .req_valid(req_valid),
    .req_id(req_id), .req_prio(req_prio));

  typedef struct {
    logic       v;
    logic [5:0] id;
    logic [7:0] p;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] mp [48];
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  function automatic exp_t predict(logic [47:0] c, logic signed [9:0] rp, string tag);
    exp_t r;
    bit hit = 0;
    r.v = 0; r.id = 0; r.p = 0; r.tag = tag;
    for (int lvl = 0; lvl < 16 && !hit; lvl++)
      for (int id = 0; id < 48 && !hit; id++)
        if (c[id] && mp[id] == 8'(lvl * 16)) begin
          hit = 1; r.id = 6'(id); r.p = mp[id];
        end
    r.v = hit && (int'(r.p) < int'(rp));
    return r;
  endfunction

  task automatic apply(logic [47:0] c, logic signed [9:0] rp, string tag);
    @(negedge clk);
    bus_we = 0;
    cand_vec = c;
    run_prio = rp;
    sb.push_back(predict(c, rp, tag));
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] s);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    if (a >= 12'h400 && a < 12'h430)
      for (int j = 0; j < 4; j++)
        if (s[j]) mp[((a - 12'h400) >> 2) * 4 + j] = d[8*j +: 8] & 8'hF0;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_we = 0; bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, e);
    end
  endtask

  function automatic logic [31:0] mword(int k);
    return {mp[4*k+3], mp[4*k+2], mp[4*k+1], mp[4*k]};
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (req_valid !== e.v || req_id !== e.id || req_prio !== e.p) begin
          n_bad++;
          $display("FAIL %s actual v=%0b id=%0d p=%h expected v=%0b id=%0d p=%h",
                   e.tag, req_valid, req_id, req_prio, e.v, e.id, e.p);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 48; i++) mp[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (req_valid !== 0 || req_id !== 0 || req_prio !== 0) begin
      n_bad++;
      $display("FAIL R1 outputs actual v=%0b id=%0d p=%h expected 0 0 00", req_valid, req_id, req_prio);
    end
    for (int k = 0; k < 12; k++) rd(12'(12'h400 + 4*k), 32'h0, "R1 reset field");

    apply('0, 10'sd256, "R5 no candidate");

    wr(12'h400, 32'hFFFF_FFFF, 4'hF);
    rd(12'h400, 32'hF0F0_F0F0, "R3 low nibble dropped");

    for (int k = 0; k < 12; k++) begin
      logic [31:0] w;
      for (int j = 0; j < 4; j++) w[8*j +: 8] = 8'((((4*k + j) * 7 + 3) % 16) * 16 + 9);
      wr(12'(12'h400 + 4*k), w, 4'hF);
    end
    for (int k = 0; k < 12; k++) rd(12'(12'h400 + 4*k), mword(k), "R2 word map");

    wr(12'h408, 32'h1122_5A33, 4'b0010);
    rd(12'h408, mword(2), "R4 single lane strobe");
    wr(12'h430, 32'hFFFF_FFFF, 4'hF);
    wr(12'h3FC, 32'hFFFF_FFFF, 4'hF);
    for (int k = 0; k < 12; k++) rd(12'(12'h400 + 4*k), mword(k), "R4 outside window write");
    rd(12'h430, 32'h0, "R4 outside window read");

    for (int i = 0; i < 48; i += 5) apply(48'(1) << i, 10'sd256, "R6 single candidate");
    apply(48'hFFFF_FFFF_FFFF, 10'sd256, "R6 all candidates");
    apply(48'h0F0F_0000_F0F0, 10'sd256, "R6 mixed candidates");

    wr(12'h404, 32'h2000_0000, 4'b1000);
    wr(12'h420, 32'h0000_2F00, 4'b0010);
    apply((48'(1) << 7) | (48'(1) << 33), 10'sd256, "R7 tie lowest id");
    apply((48'(1) << 7) | (48'(1) << 33), 10'sd32, "R8 equal no preempt");
    apply((48'(1) << 7) | (48'(1) << 33), 10'sd33, "R8 strictly higher");
    apply((48'(1) << 7) | (48'(1) << 33), 10'sd31, "R8 below");
    apply((48'(1) << 7) | (48'(1) << 33), -10'sd1, "R9 system exception");
    apply((48'(1) << 7) | (48'(1) << 33), -10'sd4, "R9 reset level");

    wr(12'h420, 32'h0000_1000, 4'b0010);
    apply((48'(1) << 7) | (48'(1) << 33), 10'sd256, "R10 write visible next");

    wr(12'h414, 32'hF000_0000, 4'b1000);
    apply(48'(1) << 23, 10'sd300, "R9 idle grants 240");
    apply(48'(1) << 23, 10'sd240, "R8 240 equal");

    for (int n = 0; n < 400; n++) begin
      logic [47:0] c;
      logic signed [9:0] rp;
      step_lfsr(); c[31:0] = lfsr;
      step_lfsr(); c[47:32] = lfsr[15:0];
      step_lfsr();
      if (lfsr[0]) c = c & {lfsr, lfsr[15:0]};
      step_lfsr();
      rp = 10'($signed(10'(lfsr[9:0] % 320)) - 10'sd12);
      if (n % 37 == 0) begin
        step_lfsr();
        wr(12'(12'h400 + 4 * (lfsr[7:0] % 12)), lfsr, 4'(lfsr[31:28]));
      end
      apply(c, rp, "R6 R7 R8 random");
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule